// File: doc/BRIEF.md
# Flash Status Byte Two Controller

This block keeps the second status byte of a serial NOR flash device and changes it in response to instruction strobes that have already been decoded. It handles four kinds of bit. The first is a suspend flag that only reports state. The second is a group of one-time lock bits that can be set but never cleared. The third is a quad-enable bit that decides whether two shared pins carry data or act as write-protect and hold. The last is two plain configuration bits. The block also tracks a four-wire command mode, which may be entered only while quad-enable is already set.

Two reset inputs are provided. The active-low `rstN` stands for a factory-fresh device and clears every bit. The `pwrCycle` input stands for a power-down and power-up sequence. It clears only the volatile state, which is the suspend flag and the four-wire mode flag. The lock bits, quad-enable and the two configuration bits model non-volatile cells, so `pwrCycle` leaves them as they were. Every update is registered on the rising clock edge.

Top module: `nor_status2`

## Requirements
- R1: After `rstN` is asserted, `statusOut` is 0x00, `qpiMode` is 0, `lockedOut` is 000 and `quadPinData` is 00.
- R2: A write strobe with `wel` high loads bit 6 (complement-protect) and bit 0 (protect-select) directly from `wrData[6]` and `wrData[0]`, and loads bit 1 (quad-enable) from `wrData[1]`. A write strobe with `wel` low changes nothing.
- R3: Bit 2 of `statusOut` always reads 0, whatever is written.
- R4: Bit 7 (suspend) is set by `cmdSuspend` and cleared by `cmdResume`. If both arrive in the same cycle, resume wins. `wrData[7]` has no effect on bit 7.
- R5: Lock bits sit at bits 5, 4 and 3 (LB3, LB2, LB1). A write with `wel` high ORs `wrData[5:3]` into them, so each can be set on its own. Nothing except `rstN` returns a lock bit to 0.
- R6: `lockedOut[0]`, `lockedOut[1]` and `lockedOut[2]` report LB1, LB2 and LB3 respectively. A 1 marks the matching security page as read-only.
- R7: Both bits of `quadPinData` (bit 0 for IO2, bit 1 for IO3) equal quad-enable. A 1 means data pin and a 0 means write-protect or hold function.
- R8: `cmdEnterQpi` sets `qpiMode` only if quad-enable is 1 before the edge. Otherwise it is ignored. `cmdExitQpi` clears `qpiMode` and takes priority over a simultaneous enter.
- R9: While `qpiMode` is 1, or in the cycle an enter is accepted, a write cannot clear quad-enable. The other writable bits of that write still update.
- R10: `pwrCycle` clears bit 7 and `qpiMode`, keeps bits 6..0, and blocks every strobe presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Factory reset, active low, clears every bit |
| pwrCycle | input | 1 | Power-cycle event, clears volatile state only |
| wel | input | 1 | Write-enable latch; qualifies status writes |
| cmdSuspend | input | 1 | Decoded suspend strobe |
| cmdResume | input | 1 | Decoded resume strobe |
| cmdEnterQpi | input | 1 | Decoded enter four-wire mode strobe |
| cmdExitQpi | input | 1 | Decoded exit four-wire mode strobe |
| cmdWriteSr | input | 1 | Decoded write-status-byte-two strobe |
| wrData | input | 8 | Data byte carried by the write strobe |
| statusOut | output | 8 | Current status byte |
| qpiMode | output | 1 | Four-wire command mode active |
| lockedOut | output | 3 | Per-page read-only flags from the lock bits |
| quadPinData | output | 2 | Pin function selects for IO2/IO3, 1 = data |

## Verification
Every result of this block sits one register away from its strobe. The status byte, the mode flag, the lock flags and the pin selects all show the new value one rising edge after the strobe is presented. The bench drives inputs on the falling edge and samples shortly after the next rising edge. A reference model in the bench is advanced at that same edge from the requirements. Each step then compares every output to the model, so the same-cycle priority cases are observed in exactly the cycle they resolve: resume against suspend, exit against enter, enter against a write that clears quad-enable, and power-cycle against everything.

// File: rtl/nor_status2_pkg.sv
package nor_status2_pkg;
  localparam int STATUS_W = 8;
  localparam int LOCK_N   = 3;
  localparam int PIN_N    = 2;

  // Bit positions inside the status byte (a host decodes these)
  localparam int POS_SUS  = 7;
  localparam int POS_CMP  = 6;
  localparam int POS_LOCK = 3;  // LB1 at 3, LB2 at 4, LB3 at 5
  localparam int POS_RSV  = 2;
  localparam int POS_QE   = 1;
  localparam int POS_SRP  = 0;

  typedef struct packed {
    logic setSus;
    logic clrSus;
    logic setQpi;
    logic clrQpi;
    logic loadReg;
    logic holdQe;
  } sr2Strobe_t;
endpackage

// File: rtl/nor_status2_ctrl.sv
module nor_status2_ctrl
  import nor_status2_pkg::*;
(
  input  logic       pwrCycle,
  input  logic       wel,
  input  logic       cmdSuspend,
  input  logic       cmdResume,
  input  logic       cmdEnterQpi,
  input  logic       cmdExitQpi,
  input  logic       cmdWriteSr,
  input  logic       quadEn,
  input  logic       qpiNow,
  output sr2Strobe_t stb,
  output logic       clrVolatile
);
  logic enterOk;

  always_comb begin
    enterOk     = cmdEnterQpi && quadEn && !cmdExitQpi;
    clrVolatile = pwrCycle;
    stb         = '0;
    if (!pwrCycle) begin
      stb.clrSus  = cmdResume;
      stb.setSus  = cmdSuspend && !cmdResume;
      stb.clrQpi  = cmdExitQpi;
      stb.setQpi  = enterOk;
      stb.loadReg = cmdWriteSr && wel;
      stb.holdQe  = qpiNow || (cmdEnterQpi && quadEn);
    end
  end
endmodule

// File: rtl/nor_status2_dp.sv
module nor_status2_dp
  import nor_status2_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sr2Strobe_t          stb,
  input  logic                clrVolatile,
  input  logic [STATUS_W-1:0] wrData,
  output logic [STATUS_W-1:0] statusByte,
  output logic                qpiReg,
  output logic                quadEn,
  output logic [LOCK_N-1:0]   lockBits
);
  logic susReg;
  logic cmpReg;
  logic srpReg;
  logic qeReg;

  // Volatile state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      susReg <= 1'b0;
      qpiReg <= 1'b0;
    end else if (clrVolatile) begin
      susReg <= 1'b0;
      qpiReg <= 1'b0;
    end else begin
      if (stb.clrSus)      susReg <= 1'b0;
      else if (stb.setSus) susReg <= 1'b1;
      if (stb.clrQpi)      qpiReg <= 1'b0;
      else if (stb.setQpi) qpiReg <= 1'b1;
    end
  end

  // Non-volatile stand-ins: untouched by clrVolatile
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= 1'b0;
      srpReg <= 1'b0;
      qeReg  <= 1'b0;
    end else if (stb.loadReg) begin
      cmpReg <= wrData[POS_CMP];
      srpReg <= wrData[POS_SRP];
      qeReg  <= stb.holdQe ? (qeReg | wrData[POS_QE]) : wrData[POS_QE];
    end
  end

  // One-time lock bits: set-only cells
  for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            lockBits[i] <= 1'b0;
      else if (stb.loadReg) lockBits[i] <= lockBits[i] | wrData[POS_LOCK+i];
    end
  end

  always_comb begin
    statusByte                           = '0;
    statusByte[POS_SUS]                  = susReg;
    statusByte[POS_CMP]                  = cmpReg;
    statusByte[POS_LOCK+LOCK_N-1:POS_LOCK] = lockBits;
    statusByte[POS_RSV]                  = 1'b0;
    statusByte[POS_QE]                   = qeReg;
    statusByte[POS_SRP]                  = srpReg;
  end

  assign quadEn = qeReg;
endmodule

// File: rtl/nor_status2.sv
module nor_status2
  import nor_status2_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrCycle,
  input  logic                wel,
  input  logic                cmdSuspend,
  input  logic                cmdResume,
  input  logic                cmdEnterQpi,
  input  logic                cmdExitQpi,
  input  logic                cmdWriteSr,
  input  logic [7:0]          wrData,
  output logic [7:0]          statusOut,
  output logic                qpiMode,
  output logic [2:0]          lockedOut,
  output logic [1:0]          quadPinData
);
  sr2Strobe_t stb;
  logic       clrVolatile;
  logic       quadEn;

  nor_status2_ctrl u_ctrl (
    .pwrCycle   (pwrCycle),
    .wel        (wel),
    .cmdSuspend (cmdSuspend),
    .cmdResume  (cmdResume),
    .cmdEnterQpi(cmdEnterQpi),
    .cmdExitQpi (cmdExitQpi),
    .cmdWriteSr (cmdWriteSr),
    .quadEn     (quadEn),
    .qpiNow     (qpiMode),
    .stb        (stb),
    .clrVolatile(clrVolatile)
  );

  nor_status2_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .clrVolatile(clrVolatile),
    .wrData     (wrData),
    .statusByte (statusOut),
    .qpiReg     (qpiMode),
    .quadEn     (quadEn),
    .lockBits   (lockedOut)
  );

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    assign quadPinData[p] = quadEn;
  end
endmodule

// File: rtl/nor_status2_chk.sv
module nor_status2_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrCycle,
  input logic       wel,
  input logic       cmdEnterQpi,
  input logic       cmdWriteSr,
  input logic [7:0] statusOut,
  input logic       qpiMode,
  input logic [1:0] quadPinData
);
  // R3
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[2] == 1'b0);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusOut[5:3]) & ~statusOut[5:3]) == 3'b000));

  // R8
  qpi_needs_qe_chk: assert property (@(posedge clk) disable iff (!rstN)
    qpiMode |-> statusOut[1]);

  // R8
  enter_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnterQpi && !statusOut[1] && !qpiMode) |=> !qpiMode);

  // R9
  qe_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qpiMode && cmdWriteSr && wel && !pwrCycle) |=> statusOut[1]);

  // R10
  pwr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrCycle |=> (!statusOut[7] && !qpiMode));

  // R10
  pwr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrCycle |=> (statusOut[6:0] == $past(statusOut[6:0])));

  // R7
  pin_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(quadPinData) == (statusOut[1] ? 2 : 0));
endmodule

bind nor_status2 nor_status2_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pwrCycle   (pwrCycle),
  .wel        (wel),
  .cmdEnterQpi(cmdEnterQpi),
  .cmdWriteSr (cmdWriteSr),
  .statusOut  (statusOut),
  .qpiMode    (qpiMode),
  .quadPinData(quadPinData)
);

// File: tb/sim_nor_status2.sv
`timescale 1ns/1ps
module sim_nor_status2;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrCycle = 1'b0, wel = 1'b0;
  logic       cmdSuspend = 1'b0, cmdResume = 1'b0;
  logic       cmdEnterQpi = 1'b0, cmdExitQpi = 1'b0, cmdWriteSr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] statusOut;
  logic       qpiMode;
  logic [2:0] lockedOut;
  logic [1:0] quadPinData;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic mSus = 0, mCmp = 0, mQe = 0, mSrp = 0, mQpi = 0;
  logic [2:0] mLock = 0;

  always #2.5 clk = ~clk;

  nor_status2 u0 (
    .clk(clk), .rstN(rstN), .pwrCycle(pwrCycle), .wel(wel),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume),
    .cmdEnterQpi(cmdEnterQpi), .cmdExitQpi(cmdExitQpi),
    .cmdWriteSr(cmdWriteSr), .wrData(wrData),
    .statusOut(statusOut), .qpiMode(qpiMode),
    .lockedOut(lockedOut), .quadPinData(quadPinData)
  );

  function automatic logic [7:0] expStatus();
    return {mSus, mCmp, mLock, 1'b0, mQe, mSrp};
  endfunction

  task automatic compareAll(input string tag);
    checks++;
    if (statusOut !== expStatus() || qpiMode !== mQpi ||
        lockedOut !== mLock || quadPinData !== {2{mQe}}) begin
      errors++;
      $display("FAIL %s status=%h/%h qpi=%b/%b lock=%b/%b pins=%b/%b (actual/expected)",
               tag, statusOut, expStatus(), qpiMode, mQpi, lockedOut, mLock,
               quadPinData, {2{mQe}});
    end
  endtask

  task automatic modelEdge();
    logic enterOk, holdQe;
    if (pwrCycle) begin
      mSus = 0; mQpi = 0;
    end else begin
      enterOk = cmdEnterQpi && mQe;
      holdQe  = mQpi || enterOk;
      if (cmdResume) mSus = 0; else if (cmdSuspend) mSus = 1;
      if (cmdWriteSr && wel) begin
        mCmp  = wrData[6];
        mSrp  = wrData[0];
        mLock = mLock | wrData[5:3];
        mQe   = holdQe ? 1'b1 : wrData[1];
      end
      if (cmdExitQpi) mQpi = 0; else if (enterOk) mQpi = 1;
    end
  endtask

  // strobe bits: {pwr, wel, sus, res, ent, ext, wr}
  task automatic step(input logic [6:0] s, input logic [7:0] d, input string tag);
    @(negedge clk);
    {pwrCycle, wel, cmdSuspend, cmdResume, cmdEnterQpi, cmdExitQpi, cmdWriteSr} = s;
    wrData = d;
    @(posedge clk);
    modelEdge();
    #1;
    compareAll(tag);
    @(negedge clk);
    {pwrCycle, wel, cmdSuspend, cmdResume, cmdEnterQpi, cmdExitQpi, cmdWriteSr} = '0;
  endtask

  task automatic hardReset(input string tag);
    @(negedge clk);
    rstN = 1'b0;
    mSus = 0; mCmp = 0; mQe = 0; mSrp = 0; mQpi = 0; mLock = 0;
    repeat (2) @(negedge clk);
    #1;
    compareAll(tag);
    rstN = 1'b1;
  endtask

  localparam logic [6:0] S_PWR = 7'b1000000, S_WEL = 7'b0100000,
                         S_SUS = 7'b0010000, S_RES = 7'b0001000,
                         S_ENT = 7'b0000100, S_EXT = 7'b0000010,
                         S_WR  = 7'b0000001;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    hardReset("R1 reset state");
    step(S_WR, 8'hFF, "R2 write without wel ignored");
    step(S_WR | S_WEL, 8'h41, "R2 cmp/srp load");
    step(S_WR | S_WEL, 8'h86, "R3 R4 R7 reserved and sus ignore write, QE set");
    step(S_SUS, 8'h00, "R4 suspend sets");
    step(S_SUS | S_RES, 8'h00, "R4 resume wins tie");
    step(S_SUS, 8'h00, "R4 suspend again");
    step(S_RES, 8'h00, "R4 resume clears");
    step(S_WR | S_WEL, 8'h0A, "R5 R6 set LB1 only");
    step(S_WR | S_WEL, 8'h02, "R5 lock stays after zero write");
    step(S_WR | S_WEL, 8'h22, "R5 R6 set LB3");
    step(S_ENT, 8'h00, "R8 enter accepted with QE");
    step(S_WR | S_WEL, 8'h41, "R9 QE held in QPI, others update");
    step(S_WR | S_WEL, 8'h00, "R9 QE held, cmp/srp clear");
    step(S_EXT, 8'h00, "R8 exit clears");
    step(S_ENT | S_EXT, 8'h00, "R8 exit wins tie");
    step(S_ENT | S_WR | S_WEL, 8'h00, "R9 enter with clearing write keeps QE");
    step(S_EXT, 8'h00, "R8 exit");
    step(S_WR | S_WEL, 8'h00, "R7 QE cleared outside QPI");
    step(S_ENT, 8'h00, "R8 enter ignored when QE 0");
    step(S_WR | S_WEL, 8'h43, "R2 set QE cmp srp");
    step(S_ENT | S_SUS, 8'h00, "R8 enter and suspend");
    step(S_PWR | S_WR | S_WEL | S_RES, 8'h18, "R10 power cycle blocks strobes");
    step(S_PWR, 8'h00, "R10 power cycle idle");
    hardReset("R1 second reset clears locks");

    // sweep every write byte, outside then inside four-wire mode
    for (int q = 0; q < 2; q++) begin
      for (int d = 0; d < 256; d++) begin
        hardReset("R1 sweep reset");
        if (q == 1) begin
          step(S_WR | S_WEL, 8'h02, "R2 sweep QE set");
          step(S_ENT, 8'h00, "R8 sweep enter");
        end
        step(S_WR | S_WEL, 8'(d), q == 1 ? "R9 sweep write in QPI" : "R5 sweep write");
      end
    end

    // pseudo-random strobe mix
    hardReset("R1 random reset");
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = lfsr[6:0];
      s[6] = (lfsr[15:12] == 4'hF);
      step(s, lfsr[15:8], "R10 random mix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule